// File: doc/BRIEF.md
# Serial Frame Bit Counter

This block tracks the clock periods of each transfer frame on a two-wire or clocked serial link. A 3-bit length code chooses how many data bits the next frame carries. A format select decides whether one acknowledge period follows the data bits. The block takes single-cycle strobes for the rising and falling edges of the serial clock, and a pulse for a detected start condition. From these it produces a running period count, an acknowledge-phase flag and a one-cycle end-of-frame pulse.

An 8-bit shift register travels with the counter. In receive mode it samples the data line MSB first. In transmit mode it presents the next outgoing bit. The length field has a write rule:

- A nonzero code is taken only while the serial clock is low.
- A code written during a frame is held back until that frame finishes.
- The field clears by itself when a frame ends or a start condition arrives.

The block follows the clock level from the edge strobes. After reset it assumes the clock is high, which is the idle bus state.

Top module: `sbit_frame_counter`

## Requirements
- R1: After reset, bit_cnt, len_q, ack_phase and frame_end are all 0, and sda_out is 1 in receive mode.
- R2: The length code sets the data bits per frame. Code 3'b000 means 8 data bits. Codes 3'b001 to 3'b111 mean 1 to 7 data bits.
- R3: With fmt_twowire=1, a frame lasts data bits + 1 clock periods. With fmt_twowire=0, it lasts exactly the data bits. frame_end stays low before the last period ends.
- R4: The first SCL rise of a frame sets bit_cnt to 1. Each later rise in the frame adds 1, so bit_cnt reaches the period count of the frame and never exceeds 9.
- R5: The frame ends on the SCL fall that follows the last rise. On the next clock cycle, frame_end is high for exactly one cycle and bit_cnt is 0. At that point len_q is 0, unless a write was held during the frame.
- R6: With fmt_twowire=1, ack_phase rises one cycle after the fall that ends the last data bit. It stays high through the final rise and drops together with the frame-ending fall. With fmt_twowire=0, ack_phase stays low.
- R7: One cycle after start_det, bit_cnt, len_q and ack_phase are all 0. This holds even in the middle of a frame, and any held write is dropped.
- R8: A nonzero len_wdata write is ignored while SCL is high, and a code of 0 is accepted at any time. SCL counts as high from a rise strobe (or from reset) until the next fall strobe.
- R9: The length and format are captured at the first rise of a frame. A write accepted during a frame leaves that frame's length unchanged and appears on len_q when the frame ends.
- R10: In receive mode, rx_bit is shifted in on each data-bit rise, MSB first. An n-bit frame ends right-aligned in shift_q[n-1:0], and bits above n-1 keep their earlier values.
- R11: In transmit mode, sda_out shows tx data bit n-1 first and moves to the next lower bit after each data-bit fall. sda_out is 1 while ack_phase is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_rise | input | 1 | One-cycle strobe for a serial clock rising edge |
| scl_fall | input | 1 | One-cycle strobe for a serial clock falling edge |
| start_det | input | 1 | One-cycle pulse, start condition seen |
| fmt_twowire | input | 1 | 1 adds an acknowledge period, 0 gives a plain synchronous frame |
| len_wr | input | 1 | Length field write strobe |
| len_wdata | input | 3 | Length code to write |
| len_q | output | 3 | Current length field |
| dir_tx | input | 1 | 1 transmit, 0 receive |
| tx_load | input | 1 | Load tx_byte into the shift register |
| tx_byte | input | 8 | Byte to transmit |
| rx_bit | input | 1 | Sampled serial data line |
| sda_out | output | 1 | Data line drive value (1 = released) |
| shift_q | output | 8 | Shift register contents |
| bit_cnt | output | 4 | Clock periods counted in the current frame |
| ack_phase | output | 1 | Acknowledge period in progress |
| frame_end | output | 1 | One-cycle end-of-frame pulse |

## Verification
Every length code is run in both formats. This separates the 000-is-eight decode from the plain codes, and shows whether the acknowledge period is added in one format only. A start pulse three periods into a nine-period frame shows that the count and field clear at once, and that a fresh frame then counts normally. A nonzero write during SCL high, and a write held over a running frame, show the write-protect rule apart from the deferred update. Receive frames of 3 and 8 bits over a preloaded register show right alignment and the preserved upper bits. Transmit frames of 3 and 8 bits show the bit order and the released line during the acknowledge period.

// File: rtl/sbfc_pkg.sv
package sbfc_pkg;
  localparam int LEN_W = 3;
  localparam int DW    = 1 << LEN_W;
  localparam int CNT_W = $clog2(DW + 2);

  typedef logic [LEN_W-1:0] len_t;
  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [DW-1:0]    data_t;

  // data bits carried for a length code; all-zero selects the full width
  function automatic cnt_t data_bits(len_t code);
    if (code == '0) return cnt_t'(DW);
    return cnt_t'(code);
  endfunction

  // clock periods in a frame: data bits plus the optional acknowledge slot
  function automatic cnt_t frame_periods(len_t code, logic twowire);
    return data_bits(code) + cnt_t'(twowire);
  endfunction

  // shift only the low n bits up by one, inserting in_bit at bit 0
  function automatic data_t shift_low(data_t cur, cnt_t n, logic in_bit);
    data_t r;
    r = cur;
    for (int i = 0; i < DW; i++) begin
      if (i == 0) r[i] = in_bit;
      else if (cnt_t'(i) < n) r[i] = cur[i-1];
    end
    return r;
  endfunction
endpackage

// File: rtl/sbfc_len_reg.sv
module sbfc_len_reg import sbfc_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_rise,
  input  logic scl_fall,
  input  logic start_det,
  input  logic len_wr,
  input  len_t len_wdata,
  input  logic frame_busy,
  input  logic frame_done,
  output len_t len_q,
  output logic scl_hi,
  output logic wr_ok
);
  len_t pend_q;
  logic pend_v;

  // clock level follows the strobes; bus idles high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        scl_hi <= 1'b1;
    else if (scl_rise) scl_hi <= 1'b1;
    else if (scl_fall) scl_hi <= 1'b0;
  end

  // nonzero codes only while the clock is low
  assign wr_ok = len_wr && (!scl_hi || (len_wdata == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      pend_q <= '0;
      pend_v <= 1'b0;
    end else if (start_det) begin
      len_q  <= '0;
      pend_v <= 1'b0;
    end else if (wr_ok && frame_busy && !frame_done) begin
      pend_q <= len_wdata;
      pend_v <= 1'b1;
    end else if (wr_ok) begin
      len_q  <= len_wdata;
      pend_v <= 1'b0;
    end else if (frame_done) begin
      len_q  <= pend_v ? pend_q : '0;
      pend_v <= 1'b0;
    end
  end
endmodule

// File: rtl/sbfc_counter.sv
module sbfc_counter import sbfc_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_rise,
  input  logic scl_fall,
  input  logic start_det,
  input  logic fmt_twowire,
  input  len_t len_q,
  output cnt_t bit_cnt,
  output cnt_t data_n,
  output logic ack_phase,
  output logic frame_end,
  output logic frame_busy,
  output logic frame_done,
  output logic rise_data,
  output logic fall_data
);
  cnt_t cnt_q, tot_q, dn_q;
  logic tw_q, ack_q, fe_q;
  logic active, frame_start;

  assign active      = (cnt_q != '0);
  assign frame_start = scl_rise && !active && !start_det;
  assign frame_done  = scl_fall && active && (cnt_q == tot_q) && !start_det;
  assign frame_busy  = active || frame_start;
  assign data_n      = active ? dn_q : data_bits(len_q);
  assign rise_data   = scl_rise && !start_det && (frame_start || (active && cnt_q < dn_q));
  assign fall_data   = scl_fall && !start_det && active && (cnt_q <= dn_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tot_q <= '0;
      dn_q  <= '0;
      tw_q  <= 1'b0;
      ack_q <= 1'b0;
      fe_q  <= 1'b0;
    end else begin
      fe_q <= frame_done;
      if (start_det) begin
        cnt_q <= '0;
        ack_q <= 1'b0;
      end else if (frame_start) begin
        cnt_q <= cnt_t'(1);
        tot_q <= frame_periods(len_q, fmt_twowire);
        dn_q  <= data_bits(len_q);
        tw_q  <= fmt_twowire;
      end else if (scl_rise && active && (cnt_q != tot_q)) begin
        cnt_q <= cnt_q + cnt_t'(1);
      end else if (frame_done) begin
        cnt_q <= '0;
        ack_q <= 1'b0;
      end else if (scl_fall && active && tw_q && (cnt_q == dn_q)) begin
        ack_q <= 1'b1;
      end
    end
  end

  assign bit_cnt   = cnt_q;
  assign ack_phase = ack_q;
  assign frame_end = fe_q;
endmodule

// File: rtl/sbfc_shift.sv
module sbfc_shift import sbfc_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  dir_tx,
  input  logic  tx_load,
  input  data_t tx_byte,
  input  logic  rx_bit,
  input  logic  rise_data,
  input  logic  fall_data,
  input  cnt_t  data_n,
  input  logic  ack_phase,
  output data_t shift_q,
  output logic  sda_out
);
  data_t sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      sh_q <= '0;
    else if (tx_load)                sh_q <= tx_byte;
    else if (!dir_tx && rise_data)   sh_q <= shift_low(sh_q, data_n, rx_bit);
    else if (dir_tx && fall_data)    sh_q <= shift_low(sh_q, data_n, 1'b0);
  end

  // top bit of the active field is the next bit out
  assign sda_out = (dir_tx && !ack_phase) ? sh_q[data_n - cnt_t'(1)] : 1'b1;
  assign shift_q = sh_q;
endmodule

// File: rtl/sbit_frame_counter.sv
module sbit_frame_counter import sbfc_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             fmt_twowire,
  input  logic             len_wr,
  input  logic [LEN_W-1:0] len_wdata,
  output logic [LEN_W-1:0] len_q,
  input  logic             dir_tx,
  input  logic             tx_load,
  input  logic [DW-1:0]    tx_byte,
  input  logic             rx_bit,
  output logic             sda_out,
  output logic [DW-1:0]    shift_q,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             ack_phase,
  output logic             frame_end
);
  // named internal events, visible to the bound checker
  logic scl_hi, wr_ok;
  logic frame_busy, frame_done, rise_data, fall_data;
  cnt_t data_n;

  sbfc_len_reg u_len (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .len_wr(len_wr), .len_wdata(len_wdata),
    .frame_busy(frame_busy), .frame_done(frame_done),
    .len_q(len_q), .scl_hi(scl_hi), .wr_ok(wr_ok)
  );

  sbfc_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .fmt_twowire(fmt_twowire), .len_q(len_q),
    .bit_cnt(bit_cnt), .data_n(data_n), .ack_phase(ack_phase),
    .frame_end(frame_end), .frame_busy(frame_busy), .frame_done(frame_done),
    .rise_data(rise_data), .fall_data(fall_data)
  );

  sbfc_shift u_sh (
    .clk(clk), .rst_n(rst_n), .dir_tx(dir_tx), .tx_load(tx_load),
    .tx_byte(tx_byte), .rx_bit(rx_bit), .rise_data(rise_data),
    .fall_data(fall_data), .data_n(data_n), .ack_phase(ack_phase),
    .shift_q(shift_q), .sda_out(sda_out)
  );
endmodule

// File: rtl/sbfc_checker.sv
module sbfc_checker import sbfc_pkg::*; (
  input logic clk,
  input logic rst_n,
  input logic scl_rise,
  input logic start_det,
  input logic len_wr,
  input logic [LEN_W-1:0] len_wdata,
  input logic [LEN_W-1:0] len_q,
  input logic [CNT_W-1:0] bit_cnt,
  input logic ack_phase,
  input logic frame_end,
  input logic scl_hi,
  input logic frame_busy,
  input logic frame_done
);
  p_cnt_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= cnt_t'(DW + 1));

  p_first_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rise && !start_det && bit_cnt == '0) |=> (bit_cnt == cnt_t'(1)));

  p_end_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);

  p_done_to_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (frame_end && bit_cnt == '0));

  p_ack_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_phase |-> (bit_cnt != '0));

  p_start_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (bit_cnt == '0 && len_q == '0 && !ack_phase));

  p_write_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (len_wr && scl_hi && len_wdata != '0 && !frame_busy && !start_det)
      |=> $stable(len_q));
endmodule

bind sbit_frame_counter sbfc_checker chk_i (.*);

// File: tb/sbit_frame_counter_tb.sv
`timescale 1ns/100ps
module sbit_frame_counter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_rise = 0, scl_fall = 0, start_det = 0, fmt_twowire = 0;
  logic len_wr = 0;
  logic [2:0] len_wdata = '0;
  logic [2:0] len_q;
  logic dir_tx = 0, tx_load = 0, rx_bit = 0;
  logic [7:0] tx_byte = '0;
  logic sda_out;
  logic [7:0] shift_q;
  logic [3:0] bit_cnt;
  logic ack_phase, frame_end;

  int checks = 0;
  int errors = 0;
  logic fe;

  always #2.5 clk = ~clk;

  sbit_frame_counter dut_i (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .fmt_twowire(fmt_twowire), .len_wr(len_wr),
    .len_wdata(len_wdata), .len_q(len_q), .dir_tx(dir_tx), .tx_load(tx_load),
    .tx_byte(tx_byte), .rx_bit(rx_bit), .sda_out(sda_out), .shift_q(shift_q),
    .bit_cnt(bit_cnt), .ack_phase(ack_phase), .frame_end(frame_end)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_rise();
    @(negedge clk) scl_rise = 1;
    @(negedge clk) scl_rise = 0;
  endtask

  task automatic do_fall(output logic end_seen);
    @(negedge clk) scl_fall = 1;
    @(negedge clk) scl_fall = 0;
    end_seen = frame_end;
  endtask

  task automatic write_len(input logic [2:0] code);
    @(negedge clk) begin len_wr = 1; len_wdata = code; end
    @(negedge clk) len_wr = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start_det = 1;
    @(negedge clk) start_det = 0;
  endtask

  // R1: reset values; leaves SCL low
  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(bit_cnt == 0, "R1 bit_cnt", bit_cnt, 0);
    chk(len_q == 0, "R1 len_q", len_q, 0);
    chk(!ack_phase && !frame_end, "R1 flags", {ack_phase, frame_end}, 0);
    chk(sda_out == 1, "R1 sda_out", sda_out, 1);
    do_fall(fe);
  endtask

  // R3 R4 R5 R6: one full frame, entered and left with SCL low
  task automatic run_frame(input logic [2:0] code, input logic tw);
    int data;
    int tot;
    data = (code == 0) ? 8 : int'(code);
    tot  = data + int'(tw);
    fmt_twowire = tw;
    write_len(code);
    chk(len_q == code, "R8 low write", len_q, code);
    for (int k = 1; k <= tot; k++) begin
      do_rise();
      chk(bit_cnt == k, "R4 count", bit_cnt, k);
      chk(ack_phase == (tw && k == tot), "R6 ack at rise", ack_phase, tw && k == tot);
      do_fall(fe);
      if (k == tot) begin
        chk(fe == 1, "R5 end pulse", fe, 1);
        chk(bit_cnt == 0, "R5 cleared", bit_cnt, 0);
        chk(len_q == 0, "R5 field cleared", len_q, 0);
        @(negedge clk);
        chk(frame_end == 0, "R5 single pulse", frame_end, 0);
      end else begin
        chk(fe == 0, "R3 early end", fe, 0);
        chk(ack_phase == (tw && k == data), "R6 ack after fall", ack_phase, tw && k == data);
      end
    end
  endtask

  task automatic t_all_codes();
    for (int tw = 0; tw < 2; tw++)
      for (int c = 0; c < 8; c++)
        run_frame(3'(c), 1'(tw));
  endtask

  // R7: start condition three periods into a 9-period frame
  task automatic t_start_mid();
    fmt_twowire = 1;
    write_len(3'd0);
    for (int k = 0; k < 3; k++) begin do_rise(); do_fall(fe); end
    write_len(3'd5);
    do_rise();
    pulse_start();
    chk(bit_cnt == 0, "R7 count cleared", bit_cnt, 0);
    chk(len_q == 0, "R7 field cleared", len_q, 0);
    do_fall(fe);
    chk(fe == 0 && bit_cnt == 0, "R7 no end after start", fe, 0);
    chk(len_q == 0, "R7 held write dropped", len_q, 0);
    run_frame(3'd2, 1'b0);
  endtask

  // R8: write protection while SCL is high
  task automatic t_protect();
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    write_len(3'd6);
    chk(len_q == 0, "R8 rejected after reset", len_q, 0);
    do_fall(fe);
    write_len(3'd2);
    fmt_twowire = 0;
    do_rise();
    write_len(3'd5);
    chk(len_q == 2, "R8 field kept", len_q, 2);
    do_fall(fe);
    do_rise();
    do_fall(fe);
    chk(fe == 1, "R8 frame of 2", fe, 1);
    chk(len_q == 0, "R8 high write dropped", len_q, 0);
  endtask

  // R9: write during a frame is deferred
  task automatic t_deferred();
    fmt_twowire = 0;
    write_len(3'd2);
    do_rise();
    do_fall(fe);
    write_len(3'd7);
    chk(len_q == 2, "R9 field during frame", len_q, 2);
    do_rise();
    chk(bit_cnt == 2, "R9 count", bit_cnt, 2);
    do_fall(fe);
    chk(fe == 1, "R9 frame unchanged", fe, 1);
    chk(len_q == 7, "R9 held code applied", len_q, 7);
    for (int k = 1; k <= 7; k++) begin do_rise(); do_fall(fe); end
    chk(fe == 1, "R9 next frame length", fe, 1);
  endtask

  task automatic load(input logic [7:0] b);
    @(negedge clk) begin tx_load = 1; tx_byte = b; end
    @(negedge clk) tx_load = 0;
  endtask

  // R2 R10: receive alignment
  task automatic t_rx(input logic [2:0] code, input logic [7:0] pre, input logic [7:0] bits);
    int n;
    logic [7:0] exp;
    n = (code == 0) ? 8 : int'(code);
    dir_tx = 0;
    fmt_twowire = 0;
    load(pre);
    write_len(code);
    exp = pre;
    for (int k = n - 1; k >= 0; k--) begin
      rx_bit = bits[k];
      exp[k] = bits[k];
      do_rise();
      do_fall(fe);
    end
    chk(shift_q == exp, "R10 rx alignment", shift_q, exp);
    chk(fe == 1, "R2 data bits", fe, 1);
  endtask

  // R11: transmit order and released line in ack
  task automatic t_tx(input logic [2:0] code, input logic tw, input logic [7:0] b);
    int n;
    n = (code == 0) ? 8 : int'(code);
    dir_tx = 1;
    fmt_twowire = tw;
    load(b);
    write_len(code);
    for (int k = n - 1; k >= 0; k--) begin
      chk(sda_out == b[k], "R11 tx bit", sda_out, b[k]);
      do_rise();
      do_fall(fe);
    end
    if (tw) begin
      chk(sda_out == 1, "R11 ack release", sda_out, 1);
      do_rise();
      chk(sda_out == 1 && ack_phase, "R11 ack release high", sda_out, 1);
      do_fall(fe);
    end
    chk(fe == 1, "R11 frame end", fe, 1);
    dir_tx = 0;
  endtask

  initial begin
    t_reset();
    t_all_codes();
    t_start_mid();
    t_protect();
    do_fall(fe);
    t_deferred();
    t_rx(3'd3, 8'hFF, 8'h02);
    t_rx(3'd0, 8'h00, 8'hC3);
    t_tx(3'd0, 1'b1, 8'hA5);
    t_tx(3'd3, 1'b0, 8'h05);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule